// File: doc/BRIEF.md
# Triggered Bus Capture Scope

This block is an on-chip logic analyser for internal signals. On every clock where its sample-enable input is high and it is not halted, it writes one data word into a circular buffer. Sparse sources, such as a converter that delivers a result only now and then, are recorded without gaps between their valid words. After arming, the scope first fills the buffer once. Only then does it listen to its trigger input. Once a trigger is accepted, it keeps a programmable number of further samples and then freezes the record and raises an interrupt.

Software reaches the scope through a Wishbone-style slave with two word registers. A control/status register rearms the scope, sets the holdoff count and reports the capture progress. A data register hands out the frozen record one sample per read, starting with the oldest. Repeated reads of that single address therefore walk through the whole capture. The sample side and the bus side share one clock. The slave never stalls and acknowledges each strobe on the following clock.

Top module: `capture_scope`

## Requirements
- R1: After reset, the status word shows primed, triggered and stopped as 0, the holdoff field as 0 and the depth field as log2 of the buffer depth, and `irq` is low.
- R2: Every clock with `wbCyc` and `wbStb` high is answered by `wbAck` high for exactly the next clock, `wbAck` is low otherwise, and `wbStall` is always low.
- R3: A sample is stored only on a clock where `smpEn` is high and the scope is not stopped. Samples offered after the stop leave the record unchanged.
- R4: The primed flag (status bit 27) sets once DEPTH samples have been stored since arming. A trigger before that point is ignored, including one on the same clock as the DEPTH-th sample.
- R5: An accepted trigger sets the triggered flag (status bit 26). After H further stored samples, where H is the holdoff count, the stopped flag (status bit 25) sets. With H = 0, the sample on the trigger clock is the newest one kept.
- R6: `irq` equals the stopped flag. A write to the control/status register (word address bit 0 = 0) with data bit 31 set rearms the scope: it clears all three flags and `irq` and restarts the fill.
- R7: After the stop, each read of the data register (word address bit 0 = 1) returns the next stored sample, oldest first. The read after the newest sample wraps back to the oldest.
- R8: Status word layout: bit 27 primed, bit 26 triggered, bit 25 stopped, bits 24:20 log2 depth, bits 19:0 holdoff count, all other bits 0.
- R9: A write to the data register has no effect on the flags, the record or the read position.
- R10: A write to the control/status register with data bit 31 clear loads the holdoff count from data bits 19:0 and leaves the flags, `irq` and the record untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared sample and bus clock |
| rst | input | 1 | Synchronous active-high reset; arms the scope with holdoff 0 |
| smpEn | input | 1 | Sample-enable: store `smpData` this clock |
| smpTrig | input | 1 | Trigger request |
| smpData | input | DATA_W | Word to record |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAddr | input | 1 | Word address bit 0: 0 control/status, 1 data |
| wbDataIn | input | 32 | Write data |
| wbAck | output | 1 | Acknowledge, one clock after the strobe |
| wbStall | output | 1 | Always low |
| wbDataOut | output | 32 | Read data, valid with `wbAck` |
| irq | output | 1 | Capture complete |

## Verification
The assertions assume that `rst` is held high over the first clock edges. They also assume that bus strobes come with `wbCyc` high, so a strobe without a cycle is never counted as a request. The bench drives every input at the falling edge, so each value is held across exactly one rising edge. It always presents strobes together with `wbCyc` and holds `smpEn` and `smpTrig` low during every bus access. Because of this, the captured record depends only on the explicit sample steps, and a reference model inside the bench can follow it.

// File: rtl/capture_scope_pkg.sv
package capture_scope_pkg;

  // Control-to-datapath strobes, one set per clock
  typedef struct packed {
    logic rearm;   // restart fill from slot 0
    logic wrEn;    // store the current sample
    logic follow;  // read pointer tracks the write pointer (not stopped)
    logic rdAdv;   // step read pointer after a data read
  } scopeStrobes_t;

  localparam int unsigned REARM_BIT  = 31;
  localparam int unsigned PRIMED_BIT = 27;
  localparam int unsigned TRIG_BIT   = 26;
  localparam int unsigned STOP_BIT   = 25;
  localparam int unsigned DEPTH_LSB  = 20;

endpackage

// File: rtl/scope_datapath.sv
module scope_datapath
  import capture_scope_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  scopeStrobes_t     strb,
  input  logic [DATA_W-1:0] smpData,
  output logic              wrWrap,
  output logic [DATA_W-1:0] memQ
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0]     store [DEPTH];
  logic [DEPTH_LOG2-1:0] wrPtr, rdPtr, wrNext;

  assign wrNext = strb.wrEn ? DEPTH_LOG2'(wrPtr + 1'b1) : wrPtr;
  assign wrWrap = strb.wrEn && (wrPtr == '1);

  always_ff @(posedge clk) begin
    if (rst || strb.rearm) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrNext;
      if (strb.follow)     rdPtr <= wrNext;
      else if (strb.rdAdv) rdPtr <= DEPTH_LOG2'(rdPtr + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[wrPtr] <= smpData;
    memQ <= store[rdPtr];
  end

  // R3: once frozen, no slot is advanced
  a_r3_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    (!strb.follow && !strb.rearm) |=> $stable(wrPtr));

  // R7: each data read after the stop moves one slot on
  a_r7_read_steps: assert property (@(posedge clk) disable iff (rst)
    (strb.rdAdv && !strb.follow && !strb.rearm) |=> (rdPtr == DEPTH_LOG2'($past(rdPtr) + 1'b1)));

endmodule

// File: rtl/scope_ctrl.sv
module scope_ctrl
  import capture_scope_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2 = 10,
  parameter int unsigned HOLD_W     = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smpEn,
  input  logic          smpTrig,
  input  logic          wbCyc,
  input  logic          wbStb,
  input  logic          wbWe,
  input  logic          wbAddr,
  input  logic [31:0]   wbDataIn,
  input  logic          wrWrap,
  output scopeStrobes_t strb,
  output logic          wbAck,
  output logic          rdSel,
  output logic [31:0]   statusQ,
  output logic          irq
);
  logic              primed, triggered, stopped;
  logic [HOLD_W-1:0] holdoff, holdCnt;
  logic              busReq, ctrlWr, rearm;
  logic [31:0]       statusWord;
  logic              unusedBits;

  assign unusedBits = ^wbDataIn[REARM_BIT-1:HOLD_W];

  assign busReq = wbCyc && wbStb;
  assign ctrlWr = busReq && wbWe && !wbAddr;
  assign rearm  = ctrlWr && wbDataIn[REARM_BIT];

  always_comb begin
    strb.rearm  = rearm;
    strb.wrEn   = smpEn && !stopped && !rearm;
    strb.follow = !stopped;
    strb.rdAdv  = busReq && !wbWe && wbAddr && stopped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      triggered <= 1'b0;
      stopped   <= 1'b0;
      holdoff   <= '0;
      holdCnt   <= '0;
    end else begin
      if (ctrlWr) holdoff <= wbDataIn[HOLD_W-1:0];
      if (rearm) begin
        primed    <= 1'b0;
        triggered <= 1'b0;
        stopped   <= 1'b0;
        holdCnt   <= '0;
      end else if (!stopped) begin
        if (wrWrap) primed <= 1'b1;
        if (!triggered) begin
          if (primed && smpTrig) begin
            triggered <= 1'b1;
            holdCnt   <= '0;
            if (holdoff == '0) stopped <= 1'b1;
          end
        end else if (smpEn) begin
          holdCnt <= HOLD_W'(holdCnt + 1'b1);
          if (HOLD_W'(holdCnt + 1'b1) == holdoff) stopped <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[PRIMED_BIT] = primed;
    statusWord[TRIG_BIT]   = triggered;
    statusWord[STOP_BIT]   = stopped;
    statusWord[DEPTH_LSB +: 5] = 5'(DEPTH_LOG2);
    statusWord[HOLD_W-1:0] = holdoff;
  end

  always_ff @(posedge clk) begin
    if (rst) wbAck <= 1'b0;
    else     wbAck <= busReq;
    rdSel   <= wbAddr;
    statusQ <= statusWord;
  end

  assign irq = stopped;

  // R2: a request is answered on the next clock, and only then
  a_r2_ack_next: assert property (@(posedge clk) disable iff (rst) busReq |=> wbAck);
  a_r2_ack_only: assert property (@(posedge clk) disable iff (rst) !busReq |=> !wbAck);
  // R4: the trigger is honoured only once the buffer has filled
  a_r4_trig_needs_primed: assert property (@(posedge clk) disable iff (rst)
    $rose(triggered) |-> $past(primed));
  a_r4_primed_sticky: assert property (@(posedge clk) disable iff (rst)
    (primed && !rearm) |=> primed);
  // R5: a stop always follows an accepted trigger
  a_r5_stop_needs_trig: assert property (@(posedge clk) disable iff (rst)
    $rose(stopped) |-> triggered);
  // R6: rearm drops the interrupt and the trigger state
  a_r6_rearm_clears: assert property (@(posedge clk) disable iff (rst)
    rearm |=> (!irq && !triggered));

endmodule

// File: rtl/capture_scope.sv
module capture_scope
  import capture_scope_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH_LOG2 = 10,
  parameter int unsigned HOLD_W     = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smpEn,
  input  logic              smpTrig,
  input  logic [DATA_W-1:0] smpData,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic              wbAddr,
  input  logic [31:0]       wbDataIn,
  output logic              wbAck,
  output logic              wbStall,
  output logic [31:0]       wbDataOut,
  output logic              irq
);
  scopeStrobes_t     strb;
  logic              wrWrap, rdSel;
  logic [DATA_W-1:0] memQ;
  logic [31:0]       statusQ;

  scope_ctrl #(.DEPTH_LOG2(DEPTH_LOG2), .HOLD_W(HOLD_W)) u_ctrl (
    .clk(clk), .rst(rst), .smpEn(smpEn), .smpTrig(smpTrig),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAddr(wbAddr),
    .wbDataIn(wbDataIn), .wrWrap(wrWrap), .strb(strb), .wbAck(wbAck),
    .rdSel(rdSel), .statusQ(statusQ), .irq(irq)
  );

  scope_datapath #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .smpData(smpData),
    .wrWrap(wrWrap), .memQ(memQ)
  );

  assign wbStall   = 1'b0;
  assign wbDataOut = rdSel ? 32'(memQ) : statusQ;

endmodule

// File: tb/test_capture_scope.sv
module test_capture_scope;
  localparam int DL    = 3;
  localparam int DEPTH = 1 << DL;

  typedef struct packed {
    logic [19:0] hold;
    logic [7:0]  nPre;
    logic        gap;
  } vec_t;

  localparam vec_t VECS[5] = '{
    '{20'd0,  8'd8,  1'b0},
    '{20'd3,  8'd10, 1'b1},
    '{20'd7,  8'd12, 1'b0},
    '{20'd20, 8'd9,  1'b1},
    '{20'd1,  8'd15, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic smpEn = 0, smpTrig = 0;
  logic [31:0] smpData = 0;
  logic wbCyc = 0, wbStb = 0, wbWe = 0, wbAddr = 0;
  logic [31:0] wbDataIn = 0;
  logic wbAck, wbStall, irq;
  logic [31:0] wbDataOut;

  always #5 clk = ~clk;

  capture_scope #(.DATA_W(32), .DEPTH_LOG2(DL), .HOLD_W(20)) i_capture_scope (
    .clk(clk), .rst(rst), .smpEn(smpEn), .smpTrig(smpTrig), .smpData(smpData),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAddr(wbAddr),
    .wbDataIn(wbDataIn), .wbAck(wbAck), .wbStall(wbStall),
    .wbDataOut(wbDataOut), .irq(irq)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference model of the requirements
  logic [31:0] ring [DEPTH];
  int  mWr, mCount, mHold, mRd;
  logic [19:0] mHoldoff;
  bit  mTrig, mStop;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] statusExp();
    return {4'b0, (mCount >= DEPTH), mTrig, mStop, 5'(DL), mHoldoff};
  endfunction

  function automatic void modelRearm();
    mWr = 0; mCount = 0; mHold = 0; mTrig = 0; mStop = 0;
  endfunction

  function automatic void modelStep(input bit en, input bit trig, input logic [31:0] d);
    bit stopNow;
    stopNow = 0;
    if (mStop) return;
    if (!mTrig) begin
      if (mCount >= DEPTH && trig) begin
        mTrig = 1;
        if (mHoldoff == 0) stopNow = 1;
      end
    end else if (en) begin
      mHold++;
      if (mHold == int'(mHoldoff)) stopNow = 1;
    end
    if (en) begin
      ring[mWr] = d;
      mWr = (mWr + 1) % DEPTH;
      mCount++;
    end
    if (stopNow) begin
      mStop = 1;
      mRd = mWr;
    end
  endfunction

  task automatic step(input bit en, input bit trig, input logic [31:0] d);
    @(negedge clk);
    smpEn = en; smpTrig = trig; smpData = d;
    modelStep(en, trig, d);
  endtask

  task automatic busWrite(input logic a, input logic [31:0] d);
    @(negedge clk);
    smpEn = 0; smpTrig = 0;
    wbCyc = 1; wbStb = 1; wbWe = 1; wbAddr = a; wbDataIn = d;
    @(negedge clk);
    wbCyc = 0; wbStb = 0; wbWe = 0;
    check("R2 write ack", {31'b0, wbAck}, 32'd1);
    if (a == 1'b0) begin
      mHoldoff = d[19:0];
      if (d[31]) modelRearm();
    end
    @(negedge clk);
    check("R2 ack single", {31'b0, wbAck}, 32'd0);
  endtask

  task automatic busRead(input logic a, output logic [31:0] d);
    @(negedge clk);
    smpEn = 0; smpTrig = 0;
    wbCyc = 1; wbStb = 1; wbWe = 0; wbAddr = a;
    @(negedge clk);
    wbCyc = 0; wbStb = 0;
    check("R2 read ack", {30'b0, wbStall, wbAck}, 32'd1);
    d = wbDataOut;
  endtask

  task automatic readStatus(input string req);
    logic [31:0] v;
    busRead(1'b0, v);
    check(req, v, statusExp());
    check(req, {31'b0, irq}, {31'b0, mStop});
  endtask

  task automatic readRecord(input string req, input int n);
    logic [31:0] v;
    for (int j = 0; j < n; j++) begin
      busRead(1'b1, v);
      check(req, v, ring[mRd]);
      mRd = (mRd + 1) % DEPTH;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R2: watchdog expired, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    mHoldoff = 0;
    modelRearm();
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 / R8: reset state
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
    readStatus("R1 R8 reset status");

    // vector walk: R3 R5 R7
    for (int v = 0; v < 5; v++) begin
      base = 32'hA000_0000 | (v << 16);
      busWrite(1'b0, {1'b1, 11'b0, VECS[v].hold});
      readStatus("R6 rearmed");
      for (int i = 0; i < int'(VECS[v].nPre); i++) begin
        step(1'b1, 1'b0, base + i);
        if (VECS[v].gap) step(1'b0, 1'b0, 32'hDEAD_0000);
      end
      step(1'b1, 1'b1, base + 32'h100);
      for (int k = 0; !mStop && k < 64; k++) begin
        if (VECS[v].gap) step(1'b0, 1'b0, 32'hDEAD_0001);
        step(1'b1, 1'b0, base + 32'h200 + k);
      end
      for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 32'hBAD0_0000 + k); // R3 ignored after stop
      readStatus("R5 R6 stopped status");
      if (VECS[v].hold == 20'd0)
        check("R5 trigger sample newest", ring[(mWr + DEPTH - 1) % DEPTH], base + 32'h100);
      readRecord("R3 R7 record", DEPTH);
    end

    // R4: trigger before primed is ignored
    busWrite(1'b0, {1'b1, 11'b0, 20'd2});
    for (int i = 0; i < DEPTH - 1; i++) step(1'b1, 1'b1, 32'hC000_0000 + i);
    readStatus("R4 not primed");
    step(1'b1, 1'b1, 32'hC000_0007);
    readStatus("R4 primed no trigger");
    step(1'b1, 1'b1, 32'hC000_0008);
    readStatus("R4 trigger accepted");
    step(1'b1, 1'b0, 32'hC000_0009);
    step(1'b1, 1'b0, 32'hC000_000A);
    readStatus("R5 holdoff two");

    // R9: data-register write changes nothing
    readRecord("R7 first half", DEPTH / 2);
    busWrite(1'b1, 32'hFFFF_FFFF);
    readStatus("R9 status kept");
    readRecord("R9 R7 rest and wrap", DEPTH);

    // R10: holdoff load without rearm
    busWrite(1'b0, {1'b0, 11'b0, 20'd5});
    readStatus("R10 flags kept");
    readRecord("R10 record kept", 2);

    // R6: rearm clears the interrupt
    busWrite(1'b0, {1'b1, 11'b0, 20'd0});
    check("R6 irq cleared", {31'b0, irq}, 32'd0);
    readStatus("R6 cleared status");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule